// File: doc/BRIEF.md
# Block-Stepped Address Sequencer

This block produces a stream of memory addresses from five programmed values: a starting address, an increment used inside a block, a block length, a number of blocks, and an increment applied to the first address of each new block. While a sequence runs, every clock cycle with the enable high emits one address together with a valid strobe. A done pulse follows the final address of the final block. The output then holds until the next start.

The 24-bit output can be used as one wide sequence. It can also be split into two independent 12-bit sequences, a lower half and an upper half, for example to drive the read and write ports of an in-place transform memory. In the split mode the upper half, its valid strobe and its done pulse can be held back by a programmable number of cycles to line them up with downstream arithmetic latency.

Configuration is written through a plain write port into shadow registers. A sequence starts on an external start pulse, or on an internal restart right after done when auto-restart is on. That same event copies the pending configuration into the working copy.

Top module: `addr_seq_top`

## Requirements
- R1: While reset is held and right after it, `lo_valid_o`, `hi_valid_o`, `lo_done_o` and `hi_done_o` are low, and both address outputs are zero.
- R2: Register index 0 holds the start address, 1 the in-block step, 2 the block length, 3 the block count, 4 the block step and 5 the control word. A start sampled at clock edge S puts the first address on the outputs after edge S+1. Further addresses follow one per enabled edge. With start 0, step 1, length 8, one block and block step 0, the lower output is 0,1,...,7.
- R3: Within a block each address is the previous one plus the step. The first address of each block after the first is the first address of the previous block plus the block step.
- R4: An edge that samples `en_i` low emits no address. The sequence then resumes with the next address and skips none.
- R5: `lo_done_o` pulses for one cycle, in the cycle after the last valid address. The address outputs then keep their last value while valid stays low.
- R6: In single mode (control bit 0 clear) the address is the full 24-bit value `{hi_addr_o, lo_addr_o}` and wraps modulo 2^24. `hi_valid_o` and `hi_done_o` equal their lower counterparts. In dual mode each 12-bit half wraps modulo 2^12.
- R7: In dual mode (control bit 0 set) the lower half uses bits [11:0] of every parameter register and the upper half uses bits [23:12], each as an independent sequence. The block length and block count of single mode come from bits [11:0]. A count field of 0 stands for 4096.
- R8: In dual mode, control bits [5:2] give a delay D. The upper half's address, valid and done appear exactly D cycles later than they would with D = 0.
- R9: Register writes go to a shadow copy. A sequence in progress is unaffected, and the new values take effect at the next start.
- R10: A start received while a sequence runs abandons it. The edge that samples the start emits no address, and the new run begins from the start address.
- R11: With control bit 1 set, the cycle of `lo_done_o` acts as a start, so the sequence repeats and the pending configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register index |
| cfg_data_i | input | 24 | Register write data |
| start_i | input | 1 | Start or restart pulse |
| en_i | input | 1 | Advance enable |
| lo_valid_o | output | 1 | Lower-half address valid |
| lo_addr_o | output | 12 | Lower 12 address bits |
| lo_done_o | output | 1 | Lower-half (or whole) sequence done pulse |
| hi_valid_o | output | 1 | Upper-half address valid (delayed in dual mode) |
| hi_addr_o | output | 12 | Upper 12 address bits |
| hi_done_o | output | 1 | Upper-half done pulse (delayed in dual mode) |

## Verification
The properties take for granted that `start_i` and `en_i` are sampled as clean levels at the rising edge. They also assume the working configuration changes only at a start, so that a held address can move only when a valid strobe comes with it. The stimulus changes every input one time unit after a rising edge and keeps register writes and start pulses on separate edges. Before the delay or the mode is changed, the stimulus also waits long enough for the delay line to drain, so stale upper-half entries from an earlier run never meet a new expectation.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

    typedef enum logic [2:0] {
        REG_START  = 3'd0,
        REG_STEP   = 3'd1,
        REG_BSIZE  = 3'd2,
        REG_NBLK   = 3'd3,
        REG_BSTEP  = 3'd4,
        REG_CTRL   = 3'd5
    } cfg_reg_e;

    localparam int CTRL_DUAL_BIT = 0;
    localparam int CTRL_AUTO_BIT = 1;
    localparam int CTRL_DLY_LSB  = 2;

endpackage

// File: rtl/addr_seq_cfg.sv
module addr_seq_cfg
    import addr_seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [2:0]      addr_i,
    input  logic [2*AW-1:0] data_i,
    input  logic            load_i,
    output logic [2*AW-1:0] sh_start_o,
    output logic [2*AW-1:0] sh_step_o,
    output logic [2*AW-1:0] sh_bsize_o,
    output logic [2*AW-1:0] sh_nblk_o,
    output logic [2*AW-1:0] sh_bstep_o,
    output logic            act_dual_o,
    output logic            act_auto_o,
    output logic [DW-1:0]   act_delay_o
);

    localparam int RW = 2 * AW;

    typedef struct packed {
        logic [RW-1:0] start;
        logic [RW-1:0] step;
        logic [RW-1:0] bsize;
        logic [RW-1:0] nblk;
        logic [RW-1:0] bstep;
        logic          dual;
        logic          autorun;
        logic [DW-1:0] delay;
        logic          a_dual;
        logic          a_auto;
        logic [DW-1:0] a_delay;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we_i) begin
            case (addr_i)
                REG_START: c_d.start = data_i;
                REG_STEP:  c_d.step  = data_i;
                REG_BSIZE: c_d.bsize = data_i;
                REG_NBLK:  c_d.nblk  = data_i;
                REG_BSTEP: c_d.bstep = data_i;
                REG_CTRL: begin
                    c_d.dual    = data_i[CTRL_DUAL_BIT];
                    c_d.autorun = data_i[CTRL_AUTO_BIT];
                    c_d.delay   = data_i[CTRL_DLY_LSB +: DW];
                end
                default: ;
            endcase
        end
        if (load_i) begin
            c_d.a_dual  = c_q.dual;
            c_d.a_auto  = c_q.autorun;
            c_d.a_delay = c_q.delay;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign sh_start_o  = c_q.start;
    assign sh_step_o   = c_q.step;
    assign sh_bsize_o  = c_q.bsize;
    assign sh_nblk_o   = c_q.nblk;
    assign sh_bstep_o  = c_q.bstep;
    assign act_dual_o  = c_q.a_dual;
    assign act_auto_o  = c_q.a_auto;
    assign act_delay_o = c_q.a_delay;

endmodule

// File: rtl/addr_seq_engine.sv
module addr_seq_engine #(
    parameter int W  = 24,
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          en_i,
    input  logic [W-1:0]  start_i,
    input  logic [W-1:0]  step_i,
    input  logic [W-1:0]  bstep_i,
    input  logic [CW-1:0] bsize_i,
    input  logic [CW-1:0] nblk_i,
    output logic          valid_o,
    output logic [W-1:0]  addr_o,
    output logic          done_o
);

    typedef struct packed {
        logic          run;
        logic [W-1:0]  addr;
        logic [W-1:0]  base;
        logic [W-1:0]  step;
        logic [W-1:0]  bstep;
        logic [CW-1:0] idx;
        logic [CW-1:0] blk;
        logic [CW-1:0] bsz_m1;
        logic [CW-1:0] nb_m1;
        logic          ov;
        logic [W-1:0]  oaddr;
        logic          olast;
        logic          done;
    } eng_t;

    eng_t s_d, s_q;
    logic last_in_blk, last_blk;
    logic [W-1:0] next_base;

    always_comb begin
        last_in_blk = (s_q.idx == s_q.bsz_m1);
        last_blk    = (s_q.blk == s_q.nb_m1);
        next_base   = s_q.base + s_q.bstep;

        s_d       = s_q;
        s_d.done  = s_q.ov & s_q.olast;
        s_d.ov    = 1'b0;
        s_d.olast = 1'b0;

        if (load_i) begin
            s_d.run    = 1'b1;
            s_d.addr   = start_i;
            s_d.base   = start_i;
            s_d.step   = step_i;
            s_d.bstep  = bstep_i;
            s_d.idx    = '0;
            s_d.blk    = '0;
            s_d.bsz_m1 = bsize_i - 1'b1;
            s_d.nb_m1  = nblk_i - 1'b1;
        end else if (s_q.run && en_i) begin
            s_d.ov    = 1'b1;
            s_d.oaddr = s_q.addr;
            s_d.olast = last_in_blk & last_blk;
            if (last_in_blk && last_blk) begin
                s_d.run = 1'b0;
            end else if (last_in_blk) begin
                s_d.base = next_base;
                s_d.addr = next_base;
                s_d.idx  = '0;
                s_d.blk  = s_q.blk + 1'b1;
            end else begin
                s_d.addr = s_q.addr + s_q.step;
                s_d.idx  = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign valid_o = s_q.ov;
    assign addr_o  = s_q.oaddr;
    assign done_o  = s_q.done;

endmodule

// File: rtl/addr_seq_delay.sv
module addr_seq_delay #(
    parameter int PW = 14,
    parameter int DW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] sel_i,
    input  logic [PW-1:0] in_i,
    output logic [PW-1:0] out_o
);

    localparam int DEPTH = (1 << DW) - 1;

    logic [PW-1:0] tap [0:DEPTH];

    assign tap[0] = in_i;

    for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
        logic [PW-1:0] stg_d, stg_q;
        always_comb stg_d = tap[k-1];
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q <= '0;
            else         stg_q <= stg_d;
        end
        assign tap[k] = stg_q;
    end

    assign out_o = tap[sel_i];

endmodule

// File: rtl/addr_seq_top.sv
module addr_seq_top #(
    parameter int AW = 12,
    parameter int DW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_we_i,
    input  logic [2:0]      cfg_addr_i,
    input  logic [2*AW-1:0] cfg_data_i,
    input  logic            start_i,
    input  logic            en_i,
    output logic            lo_valid_o,
    output logic [AW-1:0]   lo_addr_o,
    output logic            lo_done_o,
    output logic            hi_valid_o,
    output logic [AW-1:0]   hi_addr_o,
    output logic            hi_done_o
);

    localparam int RW = 2 * AW;
    localparam int PW = AW + 2;

    logic [RW-1:0] sh_start, sh_step, sh_bsize, sh_nblk, sh_bstep;
    logic          act_dual, act_auto;
    logic [DW-1:0] act_delay;
    logic          load;

    logic          w_valid, w_done;
    logic [RW-1:0] w_addr;
    logic          n_valid, n_done;
    logic [AW-1:0] n_addr;
    logic [PW-1:0] dly_in, dly_out;

    assign load = start_i | (w_done & act_auto);

    addr_seq_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .data_i     (cfg_data_i),
        .load_i     (load),
        .sh_start_o (sh_start),
        .sh_step_o  (sh_step),
        .sh_bsize_o (sh_bsize),
        .sh_nblk_o  (sh_nblk),
        .sh_bstep_o (sh_bstep),
        .act_dual_o (act_dual),
        .act_auto_o (act_auto),
        .act_delay_o(act_delay)
    );

    // wide engine: whole sequence in single mode, lower half in dual mode
    addr_seq_engine #(.W(RW), .CW(AW)) u_wide (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .en_i    (en_i),
        .start_i (sh_start),
        .step_i  (sh_step),
        .bstep_i (sh_bstep),
        .bsize_i (sh_bsize[AW-1:0]),
        .nblk_i  (sh_nblk[AW-1:0]),
        .valid_o (w_valid),
        .addr_o  (w_addr),
        .done_o  (w_done)
    );

    // narrow engine: upper half in dual mode
    addr_seq_engine #(.W(AW), .CW(AW)) u_narrow (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .en_i    (en_i),
        .start_i (sh_start[RW-1:AW]),
        .step_i  (sh_step[RW-1:AW]),
        .bstep_i (sh_bstep[RW-1:AW]),
        .bsize_i (sh_bsize[RW-1:AW]),
        .nblk_i  (sh_nblk[RW-1:AW]),
        .valid_o (n_valid),
        .addr_o  (n_addr),
        .done_o  (n_done)
    );

    assign dly_in = {n_valid, n_done, n_addr};

    addr_seq_delay #(.PW(PW), .DW(DW)) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (act_delay),
        .in_i   (dly_in),
        .out_o  (dly_out)
    );

    assign lo_valid_o = w_valid;
    assign lo_addr_o  = w_addr[AW-1:0];
    assign lo_done_o  = w_done;

    always_comb begin
        if (act_dual) begin
            hi_valid_o = dly_out[PW-1];
            hi_done_o  = dly_out[PW-2];
            hi_addr_o  = dly_out[AW-1:0];
        end else begin
            hi_valid_o = w_valid;
            hi_done_o  = w_done;
            hi_addr_o  = w_addr[RW-1:AW];
        end
    end

endmodule

// File: rtl/addr_seq_chk.sv
module addr_seq_chk #(
    parameter int AW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          en_i,
    input logic          lo_valid_o,
    input logic [AW-1:0] lo_addr_o,
    input logic          lo_done_o
);

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!lo_valid_o && !lo_done_o));

    // R4
    en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !lo_valid_o);

    // R10
    restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !lo_valid_o);

    // R5
    done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_done_o |-> (!lo_valid_o && $past(lo_valid_o)));

    // R5
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lo_addr_o) |-> lo_valid_o);

endmodule

bind addr_seq_top addr_seq_chk #(.AW(AW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .en_i       (en_i),
    .lo_valid_o (lo_valid_o),
    .lo_addr_o  (lo_addr_o),
    .lo_done_o  (lo_done_o)
);

// File: tb/tb_addr_seq_top.sv
`timescale 1ns/1ps
module tb_addr_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  waddr = '0;
    logic [23:0] wdata = '0;
    logic        start = 1'b0;
    logic        en = 1'b1;
    logic        lo_valid, lo_done, hi_valid, hi_done;
    logic [11:0] lo_addr, hi_addr;

    addr_seq_top dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(waddr),
        .cfg_data_i(wdata), .start_i(start), .en_i(en),
        .lo_valid_o(lo_valid), .lo_addr_o(lo_addr), .lo_done_o(lo_done),
        .hi_valid_o(hi_valid), .hi_addr_o(hi_addr), .hi_done_o(hi_done)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    string req = "R2";
    logic [11:0] qlo[$];
    logic [11:0] qhi[$];
    int lo_first = -1, hi_first = -1, lo_last = -1;
    int lo_done_c = -1, hi_done_c = -1, done_cnt = 0, s_cyc = 0;

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // monitor: pops expected items as addresses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_valid) begin
                if (lo_first < 0) lo_first = cyc;
                lo_last = cyc;
                if (qlo.size() == 0) chk(1'b0, req, "unexpected lower address", lo_addr, 0);
                else begin
                    logic [11:0] e;
                    e = qlo.pop_front();
                    chk(lo_addr == e, req, "lower address", lo_addr, e);
                end
            end
            if (hi_valid) begin
                if (hi_first < 0) hi_first = cyc;
                if (qhi.size() == 0) chk(1'b0, req, "unexpected upper address", hi_addr, 0);
                else begin
                    logic [11:0] e;
                    e = qhi.pop_front();
                    chk(hi_addr == e, req, "upper address", hi_addr, e);
                end
            end
            if (lo_done) begin done_cnt++; lo_done_c = cyc; end
            if (hi_done) hi_done_c = cyc;
        end
    end

    // mode 0: 24-bit single, 1: lower half only, 2: upper half only
    task automatic push_seq(input int mode, input logic [23:0] st, input logic [23:0] sp,
                            input int bs, input int nb, input logic [23:0] bst, input int lim);
        logic [23:0] base, a;
        int n = 0;
        base = st;
        for (int b = 0; b < nb; b++) begin
            a = base;
            for (int i = 0; i < bs; i++) begin
                if (lim < 0 || n < lim) begin
                    if (mode == 0) begin qlo.push_back(a[11:0]); qhi.push_back(a[23:12]); end
                    else if (mode == 1) qlo.push_back(a[11:0]);
                    else qhi.push_back(a[11:0]);
                end
                n++;
                a = (mode == 0) ? a + sp : {12'h000, a[11:0] + sp[11:0]};
            end
            base = (mode == 0) ? base + bst : {12'h000, base[11:0] + bst[11:0]};
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(posedge clk); #1 we = 1'b1; waddr = a; wdata = d;
        @(posedge clk); #1 we = 1'b0;
    endtask

    task automatic prog(input logic [23:0] st, input logic [23:0] sp, input logic [23:0] bs,
                        input logic [23:0] nb, input logic [23:0] bst, input logic [23:0] ctl);
        wr(3'd0, st); wr(3'd1, sp); wr(3'd2, bs); wr(3'd3, nb); wr(3'd4, bst); wr(3'd5, ctl);
    endtask

    task automatic go();
        lo_first = -1; hi_first = -1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 s_cyc = cyc; start = 1'b0;
    endtask

    task automatic settle();
        int guard = 0;
        while ((qlo.size() != 0 || qhi.size() != 0) && guard < 10000) begin
            @(posedge clk); guard++;
        end
        repeat (24) @(posedge clk);
        chk(qlo.size() == 0 && qhi.size() == 0, req, "expected items left over",
            qlo.size() + qhi.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs during reset
        chk(!lo_valid && !hi_valid && !lo_done && !hi_done && lo_addr == 0 && hi_addr == 0,
            "R1", "outputs in reset", {lo_valid, hi_valid, lo_done, hi_done}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!lo_valid && !hi_valid && lo_addr == 0 && hi_addr == 0,
            "R1", "outputs after reset", {lo_valid, hi_valid}, 0);

        // R2, R5: basic count and timing
        req = "R2";
        prog(24'd0, 24'd1, 24'd8, 24'd1, 24'd0, 24'd0);
        push_seq(0, 24'd0, 24'd1, 8, 1, 24'd0, -1);
        go();
        settle();
        chk(lo_first == s_cyc + 1, "R2", "first address cycle", lo_first, s_cyc + 1);
        chk(lo_last == s_cyc + 8, "R2", "last address cycle", lo_last, s_cyc + 8);
        chk(lo_done_c == lo_last + 1, "R5", "done cycle", lo_done_c, lo_last + 1);
        @(negedge clk);
        chk(lo_addr == 12'd7 && !lo_valid, "R5", "held address", lo_addr, 7);

        // R3, R6: 24-bit single mode with wrap
        req = "R3";
        prog(24'hFFFFF0, 24'd5, 24'd3, 24'd4, 24'h000100, 24'd0);
        push_seq(0, 24'hFFFFF0, 24'd5, 3, 4, 24'h000100, -1);
        go();
        settle();

        // R4: enable pause
        req = "R4";
        prog(24'h000010, 24'd3, 24'd4, 24'd2, 24'h000020, 24'd0);
        push_seq(0, 24'h000010, 24'd3, 4, 2, 24'h000020, -1);
        go();
        @(posedge clk); @(posedge clk); #1 en = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!lo_valid, "R4", "valid while disabled", lo_valid, 0);
        end
        @(posedge clk); #1 en = 1'b1;
        settle();

        // R7, R6: dual mode, no delay, lower half wraps
        req = "R7";
        prog(24'h100FFE, 24'h002001, 24'h003003, 24'h002002, 24'h010800, 24'd1);
        push_seq(1, 24'hFFE, 24'd1, 3, 2, 24'h800, -1);
        push_seq(2, 24'h100, 24'd2, 3, 2, 24'h010, -1);
        go();
        settle();
        chk(hi_first == lo_first, "R7", "upper start cycle at zero delay", hi_first, lo_first);

        // R8: delay 3 and the maximum delay 15
        req = "R8";
        wr(3'd5, 24'd1 | (24'd3 << 2));
        push_seq(1, 24'hFFE, 24'd1, 3, 2, 24'h800, -1);
        push_seq(2, 24'h100, 24'd2, 3, 2, 24'h010, -1);
        go();
        settle();
        chk(hi_first - lo_first == 3, "R8", "upper lag", hi_first - lo_first, 3);
        chk(hi_done_c - lo_done_c == 3, "R8", "upper done lag", hi_done_c - lo_done_c, 3);
        wr(3'd5, 24'd1 | (24'd15 << 2));
        push_seq(1, 24'hFFE, 24'd1, 3, 2, 24'h800, -1);
        push_seq(2, 24'h100, 24'd2, 3, 2, 24'h010, -1);
        go();
        settle();
        chk(hi_first - lo_first == 15, "R8", "upper lag at max", hi_first - lo_first, 15);

        // R9: shadow write during a run
        req = "R9";
        prog(24'h000040, 24'd1, 24'd6, 24'd1, 24'd0, 24'd0);
        push_seq(0, 24'h000040, 24'd1, 6, 1, 24'd0, -1);
        go();
        wr(3'd0, 24'h000900);
        settle();
        push_seq(0, 24'h000900, 24'd1, 6, 1, 24'd0, -1);
        go();
        settle();

        // R10: restart after exactly four addresses
        req = "R10";
        prog(24'h000200, 24'd1, 24'd10, 24'd1, 24'd0, 24'd0);
        push_seq(0, 24'h000200, 24'd1, 10, 1, 24'd0, 4);
        push_seq(0, 24'h000200, 24'd1, 10, 1, 24'd0, -1);
        d0 = done_cnt;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (4) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        settle();
        chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);

        // R11: auto restart, switched off by a pending write
        req = "R11";
        prog(24'h000030, 24'd2, 24'd3, 24'd1, 24'd0, 24'd2);
        push_seq(0, 24'h000030, 24'd2, 3, 1, 24'd0, -1);
        push_seq(0, 24'h000030, 24'd2, 3, 1, 24'd0, -1);
        d0 = done_cnt;
        go();
        wr(3'd5, 24'd0);
        settle();
        chk(done_cnt - d0 == 2, "R11", "runs completed", done_cnt - d0, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule